// File: doc/BRIEF.md
# NOR flash command sequence decoder

This block is the command interpreter of a byte-wide parallel NOR flash, modelled as synchronous logic. Each bus write reaches it as a one-cycle event that carries a 19-bit address and an 8-bit data value. The block matches these events against keyed unlock sequences. Its outputs are one-cycle start requests to the operation engine: byte program (with its target address and data), whole-chip erase, and sector erase (with an 8-bit mask of the chosen 64 KiB sectors). It also drives a mode output that selects read-array or identification (autoselect) reads. It raises suspend and resume requests for a running sector erase.

Sector-erase commands are gathered inside a timeout window measured in clock cycles. Every further sector command adds a sector to the mask and restarts the window. Any other write closes the window and drops the sequence. When the window runs out, one combined erase is launched. While the engine reports busy, command writes have no effect. The only exceptions are the suspend and resume bytes during a sector erase.

Top module: `flash_cmd_decoder`

## Requirements
- R1: After reset every request output is low, `sect_mask` is zero and `id_mode` is 0 (read-array).
- R2: An unlock sequence is 0xAA at an address whose bits 14:0 equal 0x5555, then 0x55 at bits 14:0 equal 0x2AAA, then a command byte at 0x5555. Address bits 18:15 are not compared. A write that fails to match the expected step returns the decoder to idle and starts nothing.
- R3: Command 0xA0 arms byte program. The next accepted write, at any address and with any data, raises `prog_start` for one cycle, in the cycle after that write. `prog_addr` and `prog_data` then carry that write's address and data.
- R4: Command 0x80 followed by 0xAA@0x5555, 0x55@0x2AAA and 0x10@0x5555 raises `chip_erase_start` for one cycle after the sixth write.
- R5: Command 0x80 followed by 0xAA@0x5555, 0x55@0x2AAA and 0x30 at any address opens the window. Bit n of the mask corresponds to sector n, where n is address bits 18:16. If no write arrives, `sect_erase_start` pulses for one cycle exactly WIN_CYCLES clock edges after the edge that accepted the last 0x30 write. `sect_mask` holds the collected sectors.
- R6: A 0x30 write while the window is open ORs its sector into the mask and restarts the full window. This includes a write that lands on the edge where the window would otherwise expire.
- R7: Any write other than 0x30 while the window is open cancels the sequence. No erase starts, and the decoder returns to idle.
- R8: Command 0x90 sets `id_mode` to 1. A write of 0xF0 returns `id_mode` to 0 in any of three ways: as the third unlocked cycle, as a lone write at any address in idle, or as any other write that does not advance a sequence.
- R9: While `busy` is high and no sector erase is running, writes change neither state nor outputs.
- R10: A sector erase is running from its start request until `busy` falls while it is not suspended. During that time a 0xB0 write at any address raises `suspend_req` for one cycle, and all other writes are ignored. 0xB0 has no effect during a chip erase or a program.
- R11: While suspended, a 0x30 write raises `resume_req` for one cycle. Every other write, including a full unlocked command, is ignored.
- R12: In any cycle at most one of the five request outputs is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_valid | input | 1 | One bus write event this cycle |
| wr_addr | input | 19 | Write address |
| wr_data | input | 8 | Write data |
| busy | input | 1 | Operation engine is running a program or erase |
| prog_start | output | 1 | Byte program request pulse |
| prog_addr | output | 19 | Program target address |
| prog_data | output | 8 | Program data |
| chip_erase_start | output | 1 | Whole-chip erase request pulse |
| sect_erase_start | output | 1 | Sector erase request pulse |
| sect_mask | output | 8 | Sectors selected for erase |
| suspend_req | output | 1 | Sector erase suspend pulse |
| resume_req | output | 1 | Sector erase resume pulse |
| id_mode | output | 1 | 1 = autoselect reads, 0 = array reads |

## Verification
The window expiry and a newly arriving write can fall on the same clock edge. The bench provokes this by placing a write exactly WIN_CYCLES edges after the previous 0x30, both in directed cases and through randomly chosen gaps. When that write is 0x30, the bench expects no erase in that cycle, followed by an erase carrying both sectors a full window later. When it is any other byte, the bench expects that no erase ever starts.

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder #(
  parameter int ADDR_W     = 19,
  parameter int SECT_BITS  = 3,
  parameter int WIN_CYCLES = 5000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_valid,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  input  logic              busy,
  output logic              prog_start,
  output logic [ADDR_W-1:0] prog_addr,
  output logic [7:0]        prog_data,
  output logic              chip_erase_start,
  output logic              sect_erase_start,
  output logic [(1<<SECT_BITS)-1:0] sect_mask,
  output logic              suspend_req,
  output logic              resume_req,
  output logic              id_mode
);
  localparam int NSECT = 1 << SECT_BITS;
  localparam int CNT_W = $clog2(WIN_CYCLES) + 1;
  localparam logic [CNT_W-1:0] WIN_LOAD = CNT_W'(WIN_CYCLES - 1);

  typedef enum logic [2:0] {S_IDLE, S_U1, S_U2, S_PROG, S_E0, S_E1, S_E2, S_WIN} state_t;

  state_t           state, nxt;
  logic [CNT_W-1:0] win_cnt;
  logic             busy_q, sect_active, suspended;
  logic             adv, set_id, do_prog, do_chip, sect_first, sect_add;

  wire              at_lo   = wr_addr[14:0] == 15'h5555;
  wire              at_hi   = wr_addr[14:0] == 15'h2AAA;
  wire [NSECT-1:0]  sel_bit = NSECT'(1) << wr_addr[ADDR_W-1 -: SECT_BITS];
  wire              decode  = wr_valid && !suspended && !sect_active && !busy;

  always_comb begin
    nxt = S_IDLE;
    adv = 1'b0;
    set_id = 1'b0;
    do_prog = 1'b0;
    do_chip = 1'b0;
    sect_first = 1'b0;
    sect_add = 1'b0;
    case (state)
      S_IDLE: if (at_lo && wr_data == 8'hAA) begin nxt = S_U1; adv = 1'b1; end
      S_U1:   if (at_hi && wr_data == 8'h55) begin nxt = S_U2; adv = 1'b1; end
      S_U2:   if (at_lo) begin
                case (wr_data)
                  8'hA0: begin nxt = S_PROG; adv = 1'b1; end
                  8'h80: begin nxt = S_E0;   adv = 1'b1; end
                  8'h90: begin set_id = 1'b1; adv = 1'b1; end
                  default: ;
                endcase
              end
      S_PROG: begin do_prog = 1'b1; adv = 1'b1; end
      S_E0:   if (at_lo && wr_data == 8'hAA) begin nxt = S_E1; adv = 1'b1; end
      S_E1:   if (at_hi && wr_data == 8'h55) begin nxt = S_E2; adv = 1'b1; end
      S_E2:   if (at_lo && wr_data == 8'h10) begin do_chip = 1'b1; adv = 1'b1; end
              else if (wr_data == 8'h30) begin sect_first = 1'b1; nxt = S_WIN; adv = 1'b1; end
      S_WIN:  if (wr_data == 8'h30) begin sect_add = 1'b1; nxt = S_WIN; adv = 1'b1; end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_IDLE;
      win_cnt <= '0;
      busy_q <= 1'b0;
      sect_active <= 1'b0;
      suspended <= 1'b0;
      prog_start <= 1'b0;
      prog_addr <= '0;
      prog_data <= '0;
      chip_erase_start <= 1'b0;
      sect_erase_start <= 1'b0;
      sect_mask <= '0;
      suspend_req <= 1'b0;
      resume_req <= 1'b0;
      id_mode <= 1'b0;
    end else begin
      prog_start <= 1'b0;
      chip_erase_start <= 1'b0;
      sect_erase_start <= 1'b0;
      suspend_req <= 1'b0;
      resume_req <= 1'b0;
      busy_q <= busy;
      if (sect_active && !suspended && busy_q && !busy) sect_active <= 1'b0;

      if (wr_valid && suspended) begin
        if (wr_data == 8'h30) begin
          resume_req <= 1'b1;
          suspended <= 1'b0;
        end
      end else if (wr_valid && sect_active) begin
        if (wr_data == 8'hB0) begin
          suspend_req <= 1'b1;
          suspended <= 1'b1;
        end
      end else if (decode) begin
        state <= nxt;
        if (set_id) id_mode <= 1'b1;
        else if (wr_data == 8'hF0 && !adv) id_mode <= 1'b0;
        else if (state == S_U2 && at_lo && wr_data == 8'hF0) id_mode <= 1'b0;
        if (do_prog) begin
          prog_start <= 1'b1;
          prog_addr <= wr_addr;
          prog_data <= wr_data;
        end
        if (do_chip) chip_erase_start <= 1'b1;
        if (sect_first) begin
          sect_mask <= sel_bit;
          win_cnt <= WIN_LOAD;
        end
        if (sect_add) begin
          sect_mask <= sect_mask | sel_bit;
          win_cnt <= WIN_LOAD;
        end
        if (state == S_WIN && !adv) sect_mask <= '0;
      end else if (state == S_WIN) begin
        if (win_cnt == '0) begin
          sect_erase_start <= 1'b1;
          sect_active <= 1'b1;
          state <= S_IDLE;
        end else begin
          win_cnt <= win_cnt - 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/flash_cmd_decoder_chk.sv
module flash_cmd_decoder_chk #(
  parameter int ADDR_W    = 19,
  parameter int SECT_BITS = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_valid,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [7:0]        wr_data,
  input logic              busy,
  input logic              prog_start,
  input logic [ADDR_W-1:0] prog_addr,
  input logic [7:0]        prog_data,
  input logic              chip_erase_start,
  input logic              sect_erase_start,
  input logic [(1<<SECT_BITS)-1:0] sect_mask,
  input logic              suspend_req,
  input logic              resume_req
);
  // R12
  one_request_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({prog_start, chip_erase_start, sect_erase_start, suspend_req, resume_req}));

  // R3
  prog_fields_chk: assert property (@(posedge clk) disable iff (!rst_n)
    prog_start |-> ($past(wr_valid) && prog_addr == $past(wr_addr) && prog_data == $past(wr_data)));

  // R9
  busy_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(busy) |-> (!prog_start && !chip_erase_start));

  // R5
  expiry_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sect_erase_start |-> (!$past(wr_valid) && sect_mask != '0));

  // R10
  suspend_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
    suspend_req |-> ($past(wr_valid) && $past(wr_data) == 8'hB0));

  // R11
  resume_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
    resume_req |-> ($past(wr_valid) && $past(wr_data) == 8'h30));
endmodule

bind flash_cmd_decoder flash_cmd_decoder_chk #(.ADDR_W(ADDR_W), .SECT_BITS(SECT_BITS)) u_chk (.*);

// File: tb/tb_flash_cmd_decoder.sv
module tb_flash_cmd_decoder;
  localparam int W = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_valid = 1'b0;
  logic [18:0] wr_addr = '0;
  logic [7:0]  wr_data = '0;
  logic        busy = 1'b0;
  logic        prog_start, chip_erase_start, sect_erase_start;
  logic        suspend_req, resume_req, id_mode;
  logic [18:0] prog_addr;
  logic [7:0]  prog_data, sect_mask;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  flash_cmd_decoder #(.WIN_CYCLES(W)) dut (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_data(wr_data),
    .busy(busy), .prog_start(prog_start), .prog_addr(prog_addr), .prog_data(prog_data),
    .chip_erase_start(chip_erase_start), .sect_erase_start(sect_erase_start),
    .sect_mask(sect_mask), .suspend_req(suspend_req), .resume_req(resume_req),
    .id_mode(id_mode));

  function automatic logic [7:0] sect_bit(input logic [18:0] a);
    return 8'(1) << a[18:16];
  endfunction

  function automatic logic [18:0] key(input logic [14:0] lo);
    return {4'($urandom), lo};
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [18:0] a, input logic [7:0] d);
    wr_valid = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_valid = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic unlock(input logic [7:0] cmd);
    wr(key(15'h5555), 8'hAA);
    wr(key(15'h2AAA), 8'h55);
    wr(key(15'h5555), cmd);
  endtask

  task automatic erase_prefix();
    unlock(8'h80);
    wr(key(15'h5555), 8'hAA);
    wr(key(15'h2AAA), 8'h55);
  endtask

  task automatic run_engine();
    busy = 1'b1; idle(3); busy = 1'b0; idle(2);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=running expected=done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [7:0]  exp_mask;
    logic [18:0] a;
    logic [7:0]  d;
    bit          seen;
    void'($urandom(32'd2024));
    idle(3);
    rst_n = 1'b1;
    idle(1);

    // R1 reset state
    chk("R1 requests", {prog_start, chip_erase_start, sect_erase_start, suspend_req, resume_req}, 0);
    chk("R1 mask", sect_mask, 0);
    chk("R1 mode", id_mode, 0);

    // R3 program with high address bits set on unlock cycles (R2)
    wr(19'h7D555, 8'hAA); wr(19'h52AAA, 8'h55); wr(19'h7D555, 8'hA0);
    chk("R3 no early start", prog_start, 0);
    wr(19'h41234, 8'h5A);
    chk("R3 start", prog_start, 1);
    chk("R3 addr", prog_addr, 19'h41234);
    chk("R3 data", prog_data, 8'h5A);
    idle(1);
    chk("R3 one cycle", prog_start, 0);
    run_engine();

    // R2 mismatched unlock address
    seen = 0;
    wr(19'h05555, 8'hAA); wr(19'h02AAB, 8'h55); wr(19'h05555, 8'hA0);
    wr(19'h00100, 8'h11); seen |= prog_start;
    chk("R2 mismatch no program", seen, 0);

    // R8 autoselect enter/leave
    unlock(8'h90);
    chk("R8 enter", id_mode, 1);
    wr(19'h3ABCD, 8'hF0);
    chk("R8 lone reset", id_mode, 0);
    unlock(8'h90); unlock(8'hF0);
    chk("R8 unlocked reset", id_mode, 0);
    unlock(8'h90);
    wr(key(15'h5555), 8'hAA); wr(19'h01234, 8'hF0);
    chk("R8 reset mid sequence", id_mode, 0);

    // R4 chip erase
    erase_prefix();
    wr(key(15'h5555), 8'h10);
    chk("R4 chip erase", chip_erase_start, 1);
    chk("R4 no sector", sect_erase_start, 0);
    // R10 0xB0 ignored during chip erase
    busy = 1'b1; idle(1);
    wr(19'h00000, 8'hB0);
    chk("R10 no suspend in chip erase", suspend_req, 0);
    busy = 1'b0; idle(2);

    // R5 single sector, exact window
    erase_prefix();
    wr(19'h2ABCD, 8'h30);
    idle(W - 1);
    chk("R5 before expiry", sect_erase_start, 0);
    idle(1);
    chk("R5 at expiry", sect_erase_start, 1);
    chk("R5 mask", sect_mask, 8'h04);
    run_engine();

    // R6 collision: 0x30 on the expiry edge
    erase_prefix();
    wr(19'h10000, 8'h30);
    idle(W - 1);
    wr(19'h7FFFF, 8'h30);
    chk("R6 collision no start", sect_erase_start, 0);
    idle(W - 1);
    chk("R6 restarted window", sect_erase_start, 0);
    idle(1);
    chk("R6 start", sect_erase_start, 1);
    chk("R6 mask", sect_mask, 8'h82);
    run_engine();

    // R7 cancel with other byte on expiry edge
    erase_prefix();
    wr(19'h30000, 8'h30);
    idle(W - 1);
    wr(19'h30000, 8'h12);
    seen = sect_erase_start;
    repeat (W + 3) begin idle(1); seen |= sect_erase_start; end
    chk("R7 cancelled", seen, 0);
    wr(19'h00200, 8'h77);
    chk("R7 back to idle", prog_start, 0);

    // R9 busy blocks commands
    busy = 1'b1; seen = 0;
    unlock(8'hA0); wr(19'h00010, 8'h33); seen |= prog_start;
    unlock(8'h90);
    chk("R9 program ignored", seen, 0);
    chk("R9 mode ignored", id_mode, 0);
    busy = 1'b0;
    wr(19'h00010, 8'h33);
    chk("R9 no stale state", prog_start, 0);

    // R10/R11 suspend and resume
    erase_prefix();
    wr(19'h50000, 8'h30);
    idle(W);
    chk("R10 erase began", sect_erase_start, 1);
    busy = 1'b1; idle(1);
    wr(19'h12345, 8'h55);
    chk("R10 other byte ignored", suspend_req, 0);
    wr(19'h12345, 8'hB0);
    chk("R10 suspend", suspend_req, 1);
    busy = 1'b0; idle(2);
    seen = 0;
    unlock(8'hA0); wr(19'h00020, 8'h44); seen |= prog_start;
    chk("R11 command ignored while suspended", seen, 0);
    wr(19'h00000, 8'h30);
    chk("R11 resume", resume_req, 1);
    run_engine();
    unlock(8'hA0); wr(19'h00030, 8'h99);
    chk("R10 decoder free after erase", prog_start, 1);
    run_engine();

    // random programs with occasional corruption (R2, R3)
    for (int i = 0; i < 150; i++) begin
      int bad;
      bad = ($urandom % 4 == 0) ? int'($urandom % 3) + 1 : 0;
      a = 19'($urandom); d = 8'($urandom);
      wr(key(15'h5555), bad == 1 ? 8'hAB : 8'hAA);
      wr(key(15'h2AAA), bad == 2 ? 8'h54 : 8'h55);
      wr(key(15'h5555), bad == 3 ? 8'hA1 : 8'hA0);
      wr(a, d);
      chk("R3 random start", prog_start, bad == 0);
      if (bad == 0) begin
        chk("R3 random addr", prog_addr, a);
        chk("R3 random data", prog_data, d);
        run_engine();
      end else begin
        wr(19'h00000, 8'hF0);
      end
    end

    // random multi-sector gathering (R5, R6)
    for (int i = 0; i < 40; i++) begin
      int n;
      n = int'($urandom % 4) + 1;
      erase_prefix();
      a = 19'($urandom);
      wr(a, 8'h30);
      exp_mask = sect_bit(a);
      for (int j = 1; j < n; j++) begin
        idle(int'($urandom % W));
        a = 19'($urandom);
        wr(a, 8'h30);
        exp_mask |= sect_bit(a);
      end
      idle(W - 1);
      chk("R6 random no early start", sect_erase_start, 0);
      idle(1);
      chk("R5 random start", sect_erase_start, 1);
      chk("R6 random mask", sect_mask, exp_mask);
      run_engine();
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule